// File: doc/BRIEF.md
# Interrupt Status Controller With Selective Clear

This block gathers interrupt causes from the units around it into one 32-bit status word and drives a single interrupt line. The status word has four parts. Ten low bits latch one-cycle event pulses. Six bits pass through level status from lower-level units, and those units clear the cause themselves. One summary bit follows the interrupt line. The thirteen upper bits mirror the upper part of a 16-bit transmit completion index.

Software sees four word addresses on a small read/write port: the status word, a 32-bit mask, a 12-bit alias-clear select and an alias view of the status word. The mask has the same layout as the status word, and a mask bit at one blocks its cause. Reading the status address with the read strobe clears every latched event bit. Reading the alias address returns the same word, but it clears only the latched bits chosen in the alias-clear select. A polling driver can therefore acknowledge some causes and leave the others pending. Three of the latched events are fatal errors, and they also drive a separate fatal flag.

Top module: `irq_status_ctrl`

## Requirements
- R1: After synchronous reset the latched event bits read 0, the mask reads 32'hFFFF_FFFF, the alias-clear select reads 0, and `irq` and `fatal` are low.
- R2: A high on `ev_pulse[k]` (k in 0..9) sets status bit k at that clock edge. The bit stays set until a clearing read.
- R3: Status address 0 returns the status word on `reg_rdata` in the same cycle. When `reg_rd_en` is high, the clock edge clears all of bits [9:0].
- R4: An event pulse in the same cycle as a clearing read of its bit leaves that bit set.
- R5: Status bits [18:13] equal `sub_status[5:0]` at all times, and no read or write changes them.
- R6: Status bits [31:19] equal `tx_cidx[15:3]`.
- R7: The mask register is at address 1: 32 bits, readable and writable, reset to all ones. `irq` rises one clock edge after any status bit in [9:0] or [18:13] is set while its mask bit is 0, and falls one edge after no such bit remains.
- R8: Status bit 12 equals `irq`, and bits [11:10] read 0.
- R9: The alias-clear select is at address 2: 12 bits, with bits [31:12] reading 0. Address 3 returns the same word as address 0, and a read there with `reg_rd_en` clears only the bits in [9:0] whose select bit is 1.
- R10: Writes to address 0 and address 3 change nothing.
- R11: `fatal` is high while any of latched bits 3 (transmit tag error), 6 (receive tag error) or 9 (receive length mismatch) is set, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 10 | One-cycle event pulses for latched bits [9:0] |
| sub_status | input | 6 | Level status from lower-level units, bits [18:13] |
| tx_cidx | input | 16 | Transmit completion index; bits [15:3] are mirrored |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (triggers clear-on-read) |
| reg_addr | input | 2 | Word address: 0 status, 1 mask, 2 alias-clear select, 3 alias status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word, combinational |
| irq | output | 1 | Interrupt line, registered |
| fatal | output | 1 | Any latched fatal event pending |

## Verification
The embedded assertions check the invariant timing rules on every cycle:
- a pulsed event is never lost, including when a clear-on-read lands on it;
- a full-clear read empties the latch;
- an alias read keeps the unselected bits;
- the mask changes only on its own write;
- `irq` follows the unmasked sources with exactly one register of delay;
- writes to either status address leave the latch alone.

The field layout of the read word needs the bench's scenarios. So do the mirrored index and pass-through bits surviving reads, the reset values, the readback width of the alias-clear select, and the fatal flag ignoring the mask.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int STAT_W   = 32;
    localparam int TOP_W    = 10;
    localparam int SUB_W    = 6;
    localparam int IDX_W    = 16;
    localparam int MIR_W    = 13;
    localparam int ACLR_W   = 12;
    localparam int ADDR_W   = 2;
    localparam int SUB_LO   = 13;
    localparam int SUM_BIT  = 12;
    localparam int MIR_LO   = SUB_LO + SUB_W;
    localparam int RSV_W    = SUM_BIT - TOP_W;

    // latched bits that flag unrecoverable errors
    localparam logic [TOP_W-1:0] FATAL_SEL = 10'b10_0100_1000;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT  = 2'd0,
        A_MASK  = 2'd1,
        A_ACLR  = 2'd2,
        A_ALIAS = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [MIR_W-1:0] mirror;
        logic [SUB_W-1:0] sub;
        logic             summary;
        logic [RSV_W-1:0] rsv;
        logic [TOP_W-1:0] top;
    } status_t;

    function automatic status_t build_status(
        input logic [IDX_W-1:0] cidx,
        input logic [SUB_W-1:0] sub,
        input logic             sum,
        input logic [TOP_W-1:0] top
    );
        status_t s;
        s.mirror  = cidx[IDX_W-1 -: MIR_W];
        s.sub     = sub;
        s.summary = sum;
        s.rsv     = '0;
        s.top     = top;
        return s;
    endfunction

    // interrupt source view: summary, reserved and mirror positions forced to 0
    function automatic logic [STAT_W-1:0] irq_sources(
        input logic [SUB_W-1:0] sub,
        input logic [TOP_W-1:0] top
    );
        status_t s;
        s.mirror  = '0;
        s.sub     = sub;
        s.summary = 1'b0;
        s.rsv     = '0;
        s.top     = top;
        return s;
    endfunction

endpackage

// File: rtl/isc_event_latch.sv
module isc_event_latch #(
    parameter int W = isc_pkg::TOP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] lat_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else
                q <= (q & ~clr_i[i]) | evt_i[i];
        end
        assign lat_o[i] = q;
    end

    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((lat_o & $past(evt_i)) == $past(evt_i)));      // R4

    AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((&clr_i) && !(|evt_i)) |=> (lat_o == '0));                  // R3

    AST_SET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (clr_i == '0) |=> ((lat_o & $past(lat_o)) == $past(lat_o))); // R2

endmodule

// File: rtl/isc_cfg_regs.sv
module isc_cfg_regs
    import isc_pkg::*;
#(
    parameter int DW = STAT_W,
    parameter int CW = ACLR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     mask_o,
    output logic [CW-1:0]     aclr_o
);

    logic wr_mask, wr_aclr;
    assign wr_mask = wr_en && (reg_addr_e'(addr) == A_MASK);
    assign wr_aclr = wr_en && (reg_addr_e'(addr) == A_ACLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o <= '1;
            aclr_o <= '0;
        end else begin
            if (wr_mask) mask_o <= wdata;
            if (wr_aclr) aclr_o <= wdata[CW-1:0];
        end
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_mask |=> $stable(mask_o));                               // R7

    AST_ACLR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_aclr |=> $stable(aclr_o));                               // R9

endmodule

// File: rtl/isc_irq_gen.sv
module isc_irq_gen #(
    parameter int W = isc_pkg::STAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);

    logic [W-1:0] live;
    assign live = src_i & ~mask_i;

    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else
            irq_o <= |live;
    end

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
        ($countones(src_i & ~mask_i) != 0) |=> irq_o);               // R7

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        ((src_i & ~mask_i) == '0) |=> !irq_o);                       // R7

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TOP_W-1:0]  ev_pulse,
    input  logic [SUB_W-1:0]  sub_status,
    input  logic [IDX_W-1:0]  tx_cidx,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic              irq,
    output logic              fatal
);

    logic [TOP_W-1:0]  lat;
    logic [TOP_W-1:0]  clr;
    logic [STAT_W-1:0] mask;
    logic [ACLR_W-1:0] aclr;
    logic [STAT_W-1:0] src;
    status_t           stat;
    reg_addr_e         ra;
    logic              unused_cfg;

    assign ra = reg_addr_e'(reg_addr);
    assign unused_cfg = ^aclr[ACLR_W-1:TOP_W];

    always_comb begin
        clr = '0;
        if (reg_rd_en) begin
            if (ra == A_STAT)
                clr = '1;
            else if (ra == A_ALIAS)
                clr = aclr[TOP_W-1:0];
        end
    end

    isc_event_latch #(.W(TOP_W)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .evt_i (ev_pulse),
        .clr_i (clr),
        .lat_o (lat)
    );

    isc_cfg_regs #(.DW(STAT_W), .CW(ACLR_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .mask_o (mask),
        .aclr_o (aclr)
    );

    assign src = irq_sources(sub_status, lat);

    isc_irq_gen #(.W(STAT_W)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src),
        .mask_i (mask),
        .irq_o  (irq)
    );

    assign stat = build_status(tx_cidx, sub_status, irq, lat);

    always_comb begin
        unique case (ra)
            A_STAT, A_ALIAS: reg_rdata = stat;
            A_MASK:          reg_rdata = mask;
            A_ACLR:          reg_rdata = {{(STAT_W-ACLR_W){1'b0}}, aclr};
            default:         reg_rdata = '0;
        endcase
    end

    assign fatal = |(lat & FATAL_SEL);

    AST_ALIAS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && ra == A_ALIAS) |=>
        ((lat & $past(lat & ~aclr[TOP_W-1:0])) == $past(lat & ~aclr[TOP_W-1:0]))); // R9

    AST_STAT_WR_NOP: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && (ra == A_STAT || ra == A_ALIAS) && !reg_rd_en && ev_pulse == '0)
        |=> (lat == $past(lat)));                                    // R10

    AST_FATAL_SEEN: assert property (@(posedge clk) disable iff (rst)
        (|(ev_pulse & FATAL_SEL)) |=> fatal);                        // R11

endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  ev_pulse;
    logic [5:0]  sub_status;
    logic [15:0] tx_cidx;
    logic        reg_wr_en, reg_rd_en;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq, fatal;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_ctrl uut (
        .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .sub_status(sub_status),
        .tx_cidx(tx_cidx), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .fatal(fatal)
    );

    function automatic logic [31:0] exp_word(input logic [15:0] c, input logic [5:0] s,
                                             input logic i, input logic [9:0] t);
        return {c[15:3], s, i, 2'b00, t};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_clr(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd_en = 1'b1;
        #1;
        d = reg_rdata;
        tick();
        reg_rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [9:0] v);
        ev_pulse = v;
        tick();
        ev_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        peek(2'd0, d); chk("R1 status after reset", d, 32'h0);
        peek(2'd1, d); chk("R1 mask after reset", d, 32'hFFFF_FFFF);
        peek(2'd2, d); chk("R1 alias-clear after reset", d, 32'h0);
        chk("R1 irq/fatal after reset", {30'b0, irq, fatal}, 32'h0);
    endtask

    task automatic t_events_main_clear();
        logic [31:0] d;
        pulse(10'h005);
        peek(2'd0, d); chk("R2 events latched", d, 32'h005);
        tick(); tick();
        peek(2'd0, d); chk("R2 events held", d, 32'h005);
        pulse(10'h200);
        rd_clr(2'd0, d); chk("R3 read returns word", d, 32'h205);
        peek(2'd0, d); chk("R3 bits cleared after read", d, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        pulse(10'h002);
        ev_pulse = 10'h102;
        rd_clr(2'd0, d);
        ev_pulse = '0;
        chk("R4 read before edge", d, 32'h002);
        peek(2'd0, d); chk("R4 colliding events survive", d, 32'h102);
        rd_clr(2'd0, d);
        peek(2'd0, d); chk("R4 cleared afterwards", d, 32'h0);
    endtask

    task automatic t_sub_and_index();
        logic [31:0] d;
        sub_status = 6'h2A; tx_cidx = 16'hBEEF;
        peek(2'd0, d); chk("R5 R6 pass-through fields", d, exp_word(16'hBEEF, 6'h2A, 1'b0, 10'h0));
        rd_clr(2'd0, d);
        peek(2'd3, d); chk("R5 R6 fields survive read", d, exp_word(16'hBEEF, 6'h2A, 1'b0, 10'h0));
        sub_status = 6'h15; tx_cidx = 16'h0007;
        peek(2'd0, d); chk("R6 low index bits not mirrored", d, exp_word(16'h0007, 6'h15, 1'b0, 10'h0));
        sub_status = '0; tx_cidx = '0;
    endtask

    task automatic t_mask_irq();
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FFEF);
        peek(2'd1, d); chk("R7 mask readback", d, 32'hFFFF_FFEF);
        pulse(10'h001);
        tick();
        chk("R7 masked event keeps irq low", {31'b0, irq}, 32'h0);
        pulse(10'h010);
        chk("R7 irq one edge late", {31'b0, irq}, 32'h0);
        tick();
        chk("R7 irq asserted", {31'b0, irq}, 32'h1);
        peek(2'd0, d); chk("R8 summary bit set", d, 32'h0000_1011);
        rd_clr(2'd0, d);
        chk("R7 irq held one edge after clear", {31'b0, irq}, 32'h1);
        tick();
        chk("R7 irq drops", {31'b0, irq}, 32'h0);
        peek(2'd0, d); chk("R8 summary bit clear", d, 32'h0);
        wr(2'd1, 32'hFFFF_DFFF);
        sub_status = 6'h01;
        tick();
        chk("R7 unmasked level source raises irq", {31'b0, irq}, 32'h1);
        rd_clr(2'd0, d);
        tick();
        chk("R5 level source not cleared by read", {31'b0, irq}, 32'h1);
        sub_status = '0;
        tick();
        chk("R7 irq follows level source low", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        wr(2'd2, 32'hFFFF_F00F);
        peek(2'd2, d); chk("R9 alias-clear width", d, 32'h0000_000F);
        pulse(10'h0FF);
        rd_clr(2'd3, d); chk("R9 alias read returns word", d, 32'h0FF);
        peek(2'd0, d); chk("R9 only selected bits cleared", d, 32'h0F0);
        wr(2'd2, 32'h0);
        rd_clr(2'd3, d);
        peek(2'd0, d); chk("R9 empty select clears nothing", d, 32'h0F0);
        rd_clr(2'd0, d);
    endtask

    task automatic t_ignored_writes();
        logic [31:0] d;
        pulse(10'h021);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd3, 32'h0000_0000);
        wr(2'd3, 32'hFFFF_FFFF);
        peek(2'd0, d); chk("R10 status write ignored", d, 32'h021);
        peek(2'd1, d); chk("R10 mask untouched", d, 32'hFFFF_FFFF);
        peek(2'd2, d); chk("R10 alias-clear untouched", d, 32'h0);
        rd_clr(2'd0, d);
    endtask

    task automatic t_fatal();
        logic [31:0] d;
        pulse(10'h040);
        chk("R11 rx tag error fatal", {31'b0, fatal}, 32'h1);
        rd_clr(2'd0, d);
        chk("R11 fatal clears", {31'b0, fatal}, 32'h0);
        pulse(10'h008);
        chk("R11 tx tag error fatal", {31'b0, fatal}, 32'h1);
        rd_clr(2'd0, d);
        pulse(10'h200);
        chk("R11 length mismatch fatal", {31'b0, fatal}, 32'h1);
        rd_clr(2'd0, d);
        pulse(10'h1B7);
        chk("R11 non-fatal events", {31'b0, fatal}, 32'h0);
        rd_clr(2'd0, d);
    endtask

    initial begin
        rst = 1'b1; ev_pulse = '0; sub_status = '0; tx_cidx = '0;
        reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        #1;
        t_reset();
        t_events_main_clear();
        t_collision();
        t_sub_and_index();
        t_mask_irq();
        t_alias();
        t_ignored_writes();
        t_fatal();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule